// File: doc/BRIEF.md
# Remote DMA Byte-Port Engine

This block moves data between local packet memory and a single host-facing data port. The host sets a 16-bit start address and a 16-bit byte count, eight bits per register access. It then writes a command register to start a read or a write, or to abort. Each host strobe on the data port moves one byte, or one 16-bit word in word mode, and advances a live current-address counter. The host can read that counter back at any point in the transfer.

When the count is used up, the engine sets a sticky completion flag, returns to idle and ignores further port strobes. In read mode the engine fetches the next memory location ahead of time, so the port output already holds valid data when the host strobes it. The host can use this to walk a read from below a target address until the current address reaches the target, and then switch to a write.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the engine is idle, `done_o` is 0, and every readable register, `dport_rdata_o` and `mem_we_o` are 0.
- R2: Command register (offset 0, visible on every page, readable as written). Bits 5:3 select the operation: 001 starts a read, 010 starts a write, and 1xx aborts. The values 000 and 011 leave an ongoing transfer untouched. Bits 7:6 select the page.
- R3: The registers at offsets 1..8 are reachable only on page 0 (bits 7:6 = 00). On any other page they read as 0 and writes to them are ignored. The offsets are: 1/2 start address low/high, 3/4 count low/high, 5/6 current address low/high (read-only), 7 status, 8 configuration.
- R4: In a write transfer, each `dport_wr_i` strobe stores the port data at the current address and then advances the address by the access width.
- R5: In a read transfer, `dport_rdata_o` holds the data at the current address from the second clock after the read command, and again after every `dport_rd_i` strobe.
- R6: The current address reads back live through offsets 5 and 6 and wraps modulo 2^16.
- R7: Each strobe reduces the remaining count by the access width. The strobe that finds the remaining count at or below the width ends the transfer: the engine goes idle and sets `done_o` (status bit 6). A start command with a count of 0 sets `done_o` at once.
- R8: While idle, a port strobe writes no memory and does not move the current address.
- R9: An abort returns the engine to idle on the next clock and leaves `done_o` unchanged.
- R10: Writing 1 to status bit 6 clears `done_o`. A completion in the same cycle wins.
- R11: When configuration bit 0 is 1 (word mode), each strobe moves 16 bits: the low byte goes to the current address and the high byte to the next address, with `mem_wstrb_o` = 11. In byte mode only the low lane is used, with `mem_wstrb_o` = 01.
- R12: A new read or write command reloads the current address from the start register, even in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| dport_wr_i | input | 1 | Data port write strobe |
| dport_rd_i | input | 1 | Data port read strobe |
| dport_wdata_i | input | 16 | Data port write data |
| dport_rdata_o | output | 16 | Data port read data (prefetched) |
| mem_addr_o | output | 16 | Local memory byte address |
| mem_rdata_i | input | 16 | Memory read data: {byte at addr+1, byte at addr} |
| mem_we_o | output | 1 | Memory write enable |
| mem_wstrb_o | output | 2 | Memory byte lane strobes |
| mem_wdata_o | output | 16 | Memory write data |
| done_o | output | 1 | Remote DMA complete flag |

## Verification
The checker enforces several rules on every cycle:
- A memory write occurs only on a port write strobe, with the lane strobes that match the mode.
- An idle engine never writes memory.
- The address steps by exactly the access width on each accepted write.
- An abort idles the engine without touching the completion flag.
- The flag rises only as the result of a host access.

Other behaviour can only be shown by the bench's sweeps over start address, count and mode:
- the data actually stored and read back;
- that the completion lands on the right strobe for odd counts in word mode;
- address wrap at the top of the address space;
- page gating;
- restart.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_RD, ST_WR} xfer_st_e;

  localparam logic [3:0] RA_CMD    = 4'd0;
  localparam logic [3:0] RA_SA_LO  = 4'd1;
  localparam logic [3:0] RA_SA_HI  = 4'd2;
  localparam logic [3:0] RA_CNT_LO = 4'd3;
  localparam logic [3:0] RA_CNT_HI = 4'd4;
  localparam logic [3:0] RA_CUR_LO = 4'd5;
  localparam logic [3:0] RA_CUR_HI = 4'd6;
  localparam logic [3:0] RA_STAT   = 4'd7;
  localparam logic [3:0] RA_CFG    = 4'd8;

  localparam int DONE_BIT = 6;

  localparam logic [2:0] OP_READ  = 3'b001;
  localparam logic [2:0] OP_WRITE = 3'b010;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic [AW-1:0] cur_addr_i,
  input  logic          done_i,
  output logic [AW-1:0] start_addr_o,
  output logic [CW-1:0] count_o,
  output logic          word_mode_o,
  output logic          go_rd_o,
  output logic          go_wr_o,
  output logic          abort_o,
  output logic          done_clr_o
);
  logic [7:0]    cmd_q;
  logic [AW-1:0] sa_q;
  logic [CW-1:0] cnt_q;
  logic          cfg_q;
  logic          page0, cmd_wr, pg_we;
  logic [2:0]    op;

  assign page0  = (cmd_q[7:6] == 2'b00);
  assign cmd_wr = we_i && (addr_i == RA_CMD);
  assign pg_we  = we_i && page0;
  assign op     = wdata_i[5:3];

  assign go_rd_o    = cmd_wr && (op == OP_READ);
  assign go_wr_o    = cmd_wr && (op == OP_WRITE);
  assign abort_o    = cmd_wr && op[2];
  assign done_clr_o = pg_we && (addr_i == RA_STAT) && wdata_i[DONE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      sa_q  <= '0;
      cnt_q <= '0;
      cfg_q <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= wdata_i;
      if (pg_we) begin
        case (addr_i)
          RA_SA_LO:  sa_q[7:0]     <= wdata_i;
          RA_SA_HI:  sa_q[AW-1:8]  <= wdata_i[AW-9:0];
          RA_CNT_LO: cnt_q[7:0]    <= wdata_i;
          RA_CNT_HI: cnt_q[CW-1:8] <= wdata_i[CW-9:0];
          RA_CFG:    cfg_q         <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == RA_CMD) begin
      rdata_o = cmd_q;
    end else if (page0) begin
      case (addr_i)
        RA_SA_LO:  rdata_o = sa_q[7:0];
        RA_SA_HI:  rdata_o = sa_q[AW-1:8];
        RA_CNT_LO: rdata_o = cnt_q[7:0];
        RA_CNT_HI: rdata_o = cnt_q[CW-1:8];
        RA_CUR_LO: rdata_o = cur_addr_i[7:0];
        RA_CUR_HI: rdata_o = cur_addr_i[AW-1:8];
        RA_STAT:   rdata_o[DONE_BIT] = done_i;
        RA_CFG:    rdata_o[0] = cfg_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign start_addr_o = sa_q;
  assign count_o      = cnt_q;
  assign word_mode_o  = cfg_q;
endmodule

// File: rtl/rdma_xfer.sv
module rdma_xfer
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_rd_i,
  input  logic          go_wr_i,
  input  logic          abort_i,
  input  logic          done_clr_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic          word_mode_i,
  input  logic          dport_wr_i,
  input  logic          dport_rd_i,
  output xfer_st_e      st_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] next_addr_o,
  output logic          rd_step_o,
  output logic          wr_step_o,
  output logic          fill_o,
  output logic          done_o
);
  xfer_st_e      st_q;
  logic [AW-1:0] cur_q;
  logic [CW-1:0] rem_q;
  logic          done_q;
  logic [AW-1:0] astep;
  logic [CW-1:0] cstep;
  logic          go, cmd_any, last, step, done_set;

  assign astep   = word_mode_i ? AW'(2) : AW'(1);
  assign cstep   = word_mode_i ? CW'(2) : CW'(1);
  assign go      = go_rd_i || go_wr_i;
  assign cmd_any = go || abort_i;
  assign last    = (rem_q <= cstep);

  assign rd_step_o = (st_q == ST_RD) && dport_rd_i && !cmd_any;
  assign wr_step_o = (st_q == ST_WR) && dport_wr_i && !cmd_any;
  assign fill_o    = (st_q == ST_FILL);
  assign step      = rd_step_o || wr_step_o;
  assign done_set  = (go && (count_i == '0)) || (step && last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cur_q <= '0;
      rem_q <= '0;
    end else if (go) begin
      cur_q <= start_addr_i;
      rem_q <= count_i;
      if (count_i == '0) st_q <= ST_IDLE;
      else               st_q <= go_rd_i ? ST_FILL : ST_WR;
    end else if (abort_i) begin
      st_q <= ST_IDLE;
    end else begin
      if (st_q == ST_FILL) st_q <= ST_RD;
      if (step) begin
        cur_q <= cur_q + astep;
        rem_q <= last ? '0 : rem_q - cstep;
        if (last) st_q <= ST_IDLE;
      end
    end
  end

  // set has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         done_q <= 1'b0;
    else if (done_set)   done_q <= 1'b1;
    else if (done_clr_i) done_q <= 1'b0;
  end

  assign st_o        = st_q;
  assign cur_addr_o  = cur_q;
  assign next_addr_o = cur_q + astep;
  assign done_o      = done_q;
endmodule

// File: rtl/rdma_prefetch.sv
module rdma_prefetch #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          word_mode_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] data_o
);
  localparam int HW = DW / 2;
  logic [DW-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     buf_q <= '0;
    else if (load_i) buf_q <= word_mode_i ? mem_rdata_i : {{HW{1'b0}}, mem_rdata_i[HW-1:0]};
  end

  assign data_o = buf_q;
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          dport_wr_i,
  input  logic          dport_rd_i,
  input  logic [DW-1:0] dport_wdata_i,
  output logic [DW-1:0] dport_rdata_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_we_o,
  output logic [1:0]    mem_wstrb_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          done_o
);
  localparam int HW = DW / 2;

  logic [AW-1:0] start_addr, cur_addr, next_addr;
  logic [CW-1:0] count;
  logic          word_mode, go_rd, go_wr, abort, done_clr;
  logic          rd_step, wr_step, fill, done, busy;
  xfer_st_e      st;

  rdma_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .cur_addr_i(cur_addr), .done_i(done),
    .start_addr_o(start_addr), .count_o(count), .word_mode_o(word_mode),
    .go_rd_o(go_rd), .go_wr_o(go_wr), .abort_o(abort), .done_clr_o(done_clr)
  );

  rdma_xfer #(.AW(AW), .CW(CW)) u_xfer (
    .clk_i, .rst_ni,
    .go_rd_i(go_rd), .go_wr_i(go_wr), .abort_i(abort), .done_clr_i(done_clr),
    .start_addr_i(start_addr), .count_i(count), .word_mode_i(word_mode),
    .dport_wr_i, .dport_rd_i,
    .st_o(st), .cur_addr_o(cur_addr), .next_addr_o(next_addr),
    .rd_step_o(rd_step), .wr_step_o(wr_step), .fill_o(fill), .done_o(done)
  );

  rdma_prefetch #(.DW(DW)) u_pf (
    .clk_i, .rst_ni,
    .load_i(fill || rd_step), .word_mode_i(word_mode),
    .mem_rdata_i, .data_o(dport_rdata_o)
  );

  // on a read strobe, look one step ahead so the buffer reloads with the next item
  assign mem_addr_o  = rd_step ? next_addr : cur_addr;
  assign mem_we_o    = wr_step;
  assign mem_wstrb_o = wr_step ? (word_mode ? 2'b11 : 2'b01) : 2'b00;
  assign mem_wdata_o = word_mode ? dport_wdata_i : {{HW{1'b0}}, dport_wdata_i[HW-1:0]};
  assign done_o      = done;
  assign busy        = (st != ST_IDLE);
endmodule

// File: rtl/rdma_chk.sv
module rdma_chk
  import rdma_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [3:0]    reg_addr_i,
  input logic [7:0]    reg_wdata_i,
  input logic          dport_wr_i,
  input logic          dport_rd_i,
  input logic          mem_we_o,
  input logic [1:0]    mem_wstrb_o,
  input logic          done_o,
  input logic          busy,
  input logic          word_mode,
  input logic [AW-1:0] cur_addr,
  input logic [1:0]    st
);
  logic cmd_wr, abort_wr;
  assign cmd_wr   = reg_we_i && (reg_addr_i == RA_CMD);
  assign abort_wr = cmd_wr && reg_wdata_i[5];

  // R4
  we_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> dport_wr_i);

  // R4
  wr_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == 2'(ST_WR) && dport_wr_i && !cmd_wr) |=>
      cur_addr == $past(cur_addr) + ($past(word_mode) ? AW'(2) : AW'(1)));

  // R8
  idle_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mem_we_o);

  // R9
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_wr |=> (!busy && done_o == $past(done_o)));

  // R7
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(dport_wr_i || dport_rd_i || reg_we_i));

  // R11
  lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wstrb_o == (word_mode ? 2'b11 : 2'b01)));
endmodule

bind rdma_port_engine rdma_chk #(.AW(AW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .dport_wr_i(dport_wr_i), .dport_rd_i(dport_rd_i),
  .mem_we_o(mem_we_o), .mem_wstrb_o(mem_wstrb_o), .done_o(done_o),
  .busy(busy), .word_mode(word_mode), .cur_addr(cur_addr), .st(st)
);

// File: tb/rdma_port_engine_tb.sv
module rdma_port_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        dport_wr = 1'b0, dport_rd = 1'b0;
  logic [15:0] dport_wdata = '0;
  logic [15:0] dport_rdata;
  logic [15:0] mem_addr, mem_rdata, mem_wdata;
  logic        mem_we, done;
  logic [1:0]  mem_wstrb;

  int checks = 0, errors = 0;
  logic [7:0] mem [0:4095];
  logic [11:0] a0, a1;

  always #2 clk = ~clk;

  assign a0 = mem_addr[11:0];
  assign a1 = a0 + 12'd1;
  assign mem_rdata = {mem[a1], mem[a0]};

  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_wstrb[0]) mem[a0] <= mem_wdata[7:0];
      if (mem_wstrb[1]) mem[a1] <= mem_wdata[15:8];
    end
  end

  rdma_port_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .dport_wr_i(dport_wr), .dport_rd_i(dport_rd), .dport_wdata_i(dport_wdata), .dport_rdata_o(dport_rdata),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_we_o(mem_we),
    .mem_wstrb_o(mem_wstrb), .mem_wdata_o(mem_wdata), .done_o(done)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic cur_rd(output logic [15:0] c);
    logic [7:0] lo, hi;
    reg_rd(4'd5, lo); reg_rd(4'd6, hi);
    c = {hi, lo};
  endtask

  task automatic port_wr(input logic [15:0] d);
    @(negedge clk); dport_wr = 1'b1; dport_wdata = d;
    @(negedge clk); dport_wr = 1'b0;
  endtask

  task automatic port_rd(output logic [15:0] d);
    @(negedge clk); d = dport_rdata; dport_rd = 1'b1;
    @(negedge clk); dport_rd = 1'b0;
  endtask

  task automatic setup(input logic [15:0] sa, input logic [15:0] cnt);
    reg_wr(4'd1, sa[7:0]); reg_wr(4'd2, sa[15:8]);
    reg_wr(4'd3, cnt[7:0]); reg_wr(4'd4, cnt[15:8]);
  endtask

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'((s * 7 + k * 13 + 1) & 8'hFF);
  endfunction

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
  end

  initial begin
    logic [7:0]  r;
    logic [15:0] c, d;
    logic [15:0] starts [4];
    starts[0] = 16'h0100; starts[1] = 16'h0233; starts[2] = 16'h0FF9; starts[3] = 16'h0801;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 9; a++) begin
      reg_rd(4'(a), r);
      chk(r == 8'h00, "R1 reg reset", r, 0);
    end
    chk(done == 1'b0, "R1 done reset", done, 0);
    chk(dport_rdata == 16'h0 && mem_we == 1'b0, "R1 port reset", dport_rdata, 0);

    // R8: idle strobe ignored
    port_wr(16'h00AA);
    cur_rd(c);
    chk(c == 16'h0 && mem[0] == 8'h00, "R8 idle write ignored", c, 0);

    // sweep: mode x start x count
    for (int wm = 0; wm < 2; wm++) begin
      reg_wr(4'd8, 8'(wm));
      for (int si = 0; si < 4; si++) begin
        for (int cnt = 1; cnt <= 7; cnt++) begin
          int w, n, s, seed;
          w = wm ? 2 : 1;
          n = (cnt + w - 1) / w;
          s = starts[si];
          seed = wm * 100 + si * 10 + cnt;
          reg_wr(4'd7, 8'h40);
          setup(16'(s), 16'(cnt));
          reg_wr(4'd0, 8'h10);
          for (int k = 0; k < n; k++) begin
            port_wr({pat(seed, 2*k+1), pat(seed, 2*k)});
            cur_rd(c);
            chk(c == 16'(s + w*(k+1)), "R4 write addr advance", c, s + w*(k+1));
            if (k < n-1) chk(done == 1'b0, "R7 done not early", done, 0);
          end
          chk(done == 1'b1, "R7 done at end", done, 1);
          reg_rd(4'd7, r);
          chk(r == 8'h40, "R7 status bit6", r, 8'h40);
          // stored bytes
          for (int k = 0; k < n*w; k++) begin
            logic [7:0] e;
            e = wm ? pat(seed, k) : pat(seed, 2*k);
            chk(mem[12'(s + k)] == e, wm ? "R11 word store" : "R4 byte store", mem[12'(s+k)], e);
          end
          // R8: strobe after completion
          d = 16'(mem[12'(s + n*w)]);
          port_wr(16'hFFFF);
          cur_rd(c);
          chk(c == 16'(s + n*w) && 16'(mem[12'(s + n*w)]) == d, "R8 post-done write ignored", c, s + n*w);
          // R10: clear
          reg_wr(4'd7, 8'h40);
          chk(done == 1'b0, "R10 done clear", done, 0);
          // read back
          reg_wr(4'd0, 8'h08);
          for (int k = 0; k < n; k++) begin
            logic [15:0] e;
            e = wm ? {pat(seed, 2*k+1), pat(seed, 2*k)} : {8'h00, pat(seed, 2*k)};
            port_rd(d);
            chk(d == e, "R5 read data", d, e);
          end
          chk(done == 1'b1, "R7 read done", done, 1);
          cur_rd(c);
          port_rd(d);
          cur_rd(d);
          chk(c == d, "R8 post-done read ignored", d, c);
        end
      end
    end
    reg_wr(4'd8, 8'h00);

    // R6: wrap
    reg_wr(4'd7, 8'h40);
    setup(16'hFFFE, 16'd3);
    reg_wr(4'd0, 8'h10);
    port_wr(16'h11); port_wr(16'h22);
    cur_rd(c);
    chk(c == 16'h0000, "R6 wrap", c, 0);
    port_wr(16'h33);
    cur_rd(c);
    chk(c == 16'h0001 && mem[12'hFFE] == 8'h11 && mem[0] == 8'h33, "R6 wrap store", c, 1);

    // R9: abort
    reg_wr(4'd7, 8'h40);
    setup(16'h0500, 16'd4);
    reg_wr(4'd0, 8'h10);
    port_wr(16'h5A);
    reg_wr(4'd0, 8'h20);
    chk(done == 1'b0, "R9 abort no done", done, 0);
    port_wr(16'hA5);
    cur_rd(c);
    chk(c == 16'h0501 && mem[12'h501] == 8'h00, "R9 abort idle", c, 16'h0501);

    // R2: op 011 and 000 leave transfer running
    setup(16'h0600, 16'd3);
    reg_wr(4'd0, 8'h10);
    port_wr(16'h61);
    reg_wr(4'd0, 8'h18);
    reg_wr(4'd0, 8'h00);
    port_wr(16'h62);
    cur_rd(c);
    chk(c == 16'h0602 && mem[12'h601] == 8'h62, "R2 no-op commands", c, 16'h0602);

    // R12: restart
    setup(16'h0700, 16'd4);
    reg_wr(4'd0, 8'h10);
    cur_rd(c);
    chk(c == 16'h0700, "R12 restart reload", c, 16'h0700);

    // R7: zero count
    reg_wr(4'd7, 8'h40);
    setup(16'h0710, 16'd0);
    reg_wr(4'd0, 8'h10);
    chk(done == 1'b1, "R7 zero count", done, 1);
    port_wr(16'h77);
    chk(mem[12'h710] == 8'h00, "R8 zero count idle", mem[12'h710], 0);

    // R3: page gating
    reg_wr(4'd0, 8'h40);
    reg_rd(4'd0, r);
    chk(r == 8'h40, "R2 cmd readback page1", r, 8'h40);
    reg_rd(4'd1, r);
    chk(r == 8'h00, "R3 page1 read zero", r, 0);
    reg_wr(4'd1, 8'h55);
    reg_wr(4'd0, 8'h80);
    reg_rd(4'd7, r);
    chk(r == 8'h00, "R3 page2 status zero", r, 0);
    reg_wr(4'd0, 8'h00);
    reg_rd(4'd1, r);
    chk(r == 8'h10, "R3 page1 write ignored", r, 8'h10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule